// File: doc/BRIEF.md
# Adaptive-Complexity 8x8 Two-Dimensional DCT

This block turns one 8x8 tile of signed pixel samples into its 64 orthonormal DCT-II coefficients. It separates the transform into rows and columns. A horizontal pass takes each stored row into the frequency domain and writes the results into a transpose store. A vertical pass then reads that store by column and produces the final coefficients. Both passes share a single engine of eight parallel multipliers. The engine works against a fixed-point cosine table that is computed, not stored as a list.

A type flag arrives with each tile and chooses between two modes:
- **Detail tile:** the full computation runs.
- **Flat tile:** the tile is treated as a grid of 2x2 units, each unit represented by its top-left sample. In the horizontal pass only even rows are transformed, and each result is written to both rows of its pair. In both passes only four of the eight multipliers receive operands; they use summed cosine pairs. The horizontal pass therefore takes 32 cycles instead of 64.

The controller has three states:
- `ST_FILL` accepts 64 samples in raster order.
- `ST_ROWS` runs the horizontal pass.
- `ST_COLS` runs the vertical pass and emits one coefficient per cycle.

Its transitions are:
- `ST_FILL -> ST_ROWS` when the 64th sample is accepted.
- `ST_ROWS -> ST_COLS` after the last frequency of the last transformed row.
- `ST_COLS -> ST_FILL` after the 64th coefficient.

Top module: `dct8x8_adaptive`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and `in_ready` is high.
- R2: A sample is taken on each rising edge where `in_valid` and `in_ready` are both high. Sample k of a tile is the pixel at row k/8 and column k%8. `in_ready` is low from the edge that takes sample 64 until the cycle that presents the 64th coefficient; it is high again in that cycle.
- R3: For a detail tile, each output equals F(u,v) = sum over r,c of a(u)a(v)cos((2r+1)u*pi/16)cos((2c+1)v*pi/16)x(r,c), where a(0)=sqrt(1/8) and a(k)=1/2 otherwise. Each output is within 2 of that value rounded to an integer. The cosine constants carry 12 fractional bits, and every narrowing is rounded to nearest.
- R4: The 64 coefficients leave on 64 consecutive cycles with `out_valid` high. Coefficient F(u,v) is at position 8v+u: horizontal frequency v is the outer index and vertical frequency u the inner one.
- R5: `out_last` is high with position 63 only, and `out_valid` is low in the cycle after it.
- R6: `in_bg` is sampled with the first sample of a tile (1 = flat, 0 = detail). Its value with samples 2..64 has no effect.
- R7: For a flat tile, the outputs are the R3 transform of the tile in which each pixel (r,c) is replaced by pixel (r&~1, c&~1). Samples at odd rows or odd columns have no effect.
- R8: The first coefficient is registered 65 rising edges after the edge that takes sample 64 for a detail tile, and 33 edges after it for a flat tile.
- R9: For a flat tile, the horizontal pass transforms only even rows and writes each result into both rows of the pair. Every column the vertical pass reads therefore holds equal values in rows 2k and 2k+1.
- R10: Full-scale constant tiles do not wrap. All samples at 255 give a DC term of 2040 and all at -256 give -2048, with every other coefficient 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present on `in_pix` |
| in_pix | input | PIX_W (9) | Signed pixel sample, raster order within the tile |
| in_bg | input | 1 | Tile type, read with the first sample: 1 flat, 0 detail |
| in_ready | output | 1 | Block accepts samples |
| out_valid | output | 1 | `out_coef` holds a coefficient |
| out_coef | output | PIX_W+4 (13) | Signed coefficient, order 8v+u |
| out_last | output | 1 | Marks the 64th coefficient of a tile |

## Verification
The assertions assume the following about the inputs:
- Samples stay within the signed PIX_W range.
- A tile is always delivered as a whole, with 64 accepted samples, before its coefficients are awaited.
- The flag matters only with the first sample.

The stimulus meets these assumptions by drawing every sample from -256..255. It holds `in_valid` high until all 64 samples of a tile have been taken, and waits for `in_ready` before each tile. It also deliberately inverts `in_bg` on samples 2..64 of some tiles, so that any late flag sampling shows up at the outputs.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

    localparam int BLK       = 8;
    localparam int COEF_FRAC = 12;
    localparam int COEF_W    = 14;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_ROWS,
        ST_COLS
    } dct_state_t;

    // 0.5 * cos(m*pi/16) scaled by 2^12, m in 0..8
    function automatic int half_cos(input int m);
        case (m)
            0:       return 2048;
            1:       return 2009;
            2:       return 1892;
            3:       return 1703;
            4:       return 1448;
            5:       return 1138;
            6:       return 784;
            7:       return 400;
            default: return 0;
        endcase
    endfunction

    // orthonormal DCT-II basis value for frequency u, sample n
    function automatic int basis(input int u, input int n);
        int m;
        int s;
        if (u == 0) return 1448;
        m = ((2 * n + 1) * u) % 32;
        s = 1;
        if (m > 16) m = 32 - m;
        if (m > 8) begin
            m = 16 - m;
            s = -1;
        end
        return s * half_cos(m);
    endfunction

endpackage

// File: rtl/dct_dot8.sv
module dct_dot8
    import dct8_pkg::*;
#(
    parameter int IN_W  = 14,
    parameter int ACC_W = 32
) (
    input  logic                    half,
    input  logic [2:0]              freq,
    input  logic signed [IN_W-1:0]  vec [BLK],
    output logic signed [ACC_W-1:0] acc
);

    localparam int PROD_W = IN_W + COEF_W;

    logic signed [PROD_W-1:0] prod [BLK];

    generate
        for (genvar k = 0; k < BLK; k++) begin : g_lane
            logic signed [IN_W-1:0]   opnd;
            logic signed [COEF_W-1:0] cf;
            if (k < BLK / 2) begin : g_pair
                // in half mode lane k serves the equal pair 2k, 2k+1
                always_comb begin
                    if (half) begin
                        opnd = vec[2*k];
                        cf   = COEF_W'(basis(int'(freq), 2*k) + basis(int'(freq), 2*k+1));
                    end else begin
                        opnd = vec[k];
                        cf   = COEF_W'(basis(int'(freq), k));
                    end
                end
            end else begin : g_skip
                // upper lanes are held at zero in half mode
                always_comb begin
                    if (half) begin
                        opnd = '0;
                        cf   = '0;
                    end else begin
                        opnd = vec[k];
                        cf   = COEF_W'(basis(int'(freq), k));
                    end
                end
            end
            assign prod[k] = opnd * cf;
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < BLK; k++) begin
            acc = acc + ACC_W'(prod[k]);
        end
    end

endmodule

// File: rtl/dct_blkmem.sv
module dct_blkmem
    import dct8_pkg::*;
#(
    parameter int W = 14
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic                wr_dup,
    input  logic [2:0]          wr_row,
    input  logic [2:0]          wr_col,
    input  logic signed [W-1:0] wr_data,
    input  logic                rd_by_col,
    input  logic [2:0]          rd_idx,
    output logic signed [W-1:0] rd_vec [BLK]
);

    logic signed [W-1:0] mem [BLK][BLK];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row][wr_col] <= wr_data;
            if (wr_dup) begin
                mem[wr_row + 3'd1][wr_col] <= wr_data;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < BLK; k++) begin
            rd_vec[k] = rd_by_col ? mem[k][rd_idx] : mem[rd_idx][k];
        end
    end

endmodule

// File: rtl/dct8x8_adaptive.sv
module dct8x8_adaptive
    import dct8_pkg::*;
#(
    parameter  int PIX_W    = 9,
    parameter  int MID_FRAC = 2,
    localparam int OUT_W    = PIX_W + 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [PIX_W-1:0] in_pix,
    input  logic                    in_bg,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_coef,
    output logic                    out_last
);

    localparam int ROW_W = PIX_W + 3 + MID_FRAC;
    localparam int ACC_W = ROW_W + COEF_W + 4;
    localparam int RSH   = COEF_FRAC - MID_FRAC;
    localparam int CSH   = COEF_FRAC + MID_FRAC;

    dct_state_t state, nstate;
    logic [5:0] fill_cnt;
    logic [2:0] row_q, frq_q, col_q;
    logic       bg_q;
    logic       row_last;

    logic signed [PIX_W-1:0] pix_vec  [BLK];
    logic signed [ROW_W-1:0] tbuf_vec [BLK];
    logic signed [ROW_W-1:0] eng_vec  [BLK];
    logic signed [ACC_W-1:0] acc, rnd_row, rnd_col;
    logic signed [ROW_W-1:0] row_res;
    logic signed [OUT_W-1:0] col_res;

    assign in_ready = (state == ST_FILL);
    assign row_last = bg_q ? (row_q == 3'd6) : (row_q == 3'd7);

    dct_blkmem #(.W(PIX_W)) u_inmem (
        .clk       (clk),
        .wr_en     (in_valid && state == ST_FILL),
        .wr_dup    (1'b0),
        .wr_row    (fill_cnt[5:3]),
        .wr_col    (fill_cnt[2:0]),
        .wr_data   (in_pix),
        .rd_by_col (1'b0),
        .rd_idx    (row_q),
        .rd_vec    (pix_vec)
    );

    dct_blkmem #(.W(ROW_W)) u_tbuf (
        .clk       (clk),
        .wr_en     (state == ST_ROWS),
        .wr_dup    (bg_q),
        .wr_row    (row_q),
        .wr_col    (frq_q),
        .wr_data   (row_res),
        .rd_by_col (1'b1),
        .rd_idx    (col_q),
        .rd_vec    (tbuf_vec)
    );

    always_comb begin
        for (int k = 0; k < BLK; k++) begin
            eng_vec[k] = (state == ST_ROWS) ? ROW_W'(pix_vec[k]) : tbuf_vec[k];
        end
    end

    dct_dot8 #(.IN_W(ROW_W), .ACC_W(ACC_W)) u_dot (
        .half (bg_q),
        .freq (frq_q),
        .vec  (eng_vec),
        .acc  (acc)
    );

    assign rnd_row = acc + ACC_W'(1 <<< (RSH - 1));
    assign rnd_col = acc + ACC_W'(1 <<< (CSH - 1));
    assign row_res = ROW_W'(rnd_row >>> RSH);
    assign col_res = OUT_W'(rnd_col >>> CSH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_FILL: if (in_valid && fill_cnt == 6'd63)  nstate = ST_ROWS;
            ST_ROWS: if (frq_q == 3'd7 && row_last)      nstate = ST_COLS;
            ST_COLS: if (frq_q == 3'd7 && col_q == 3'd7) nstate = ST_FILL;
            default: nstate = ST_FILL;
        endcase
    end

    // counters and tile flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            row_q    <= '0;
            frq_q    <= '0;
            col_q    <= '0;
            bg_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_FILL: begin
                    if (in_valid) begin
                        fill_cnt <= fill_cnt + 6'd1;
                        if (fill_cnt == 6'd0) bg_q <= in_bg;
                    end
                end
                ST_ROWS: begin
                    frq_q <= frq_q + 3'd1;
                    if (frq_q == 3'd7) begin
                        row_q <= row_last ? 3'd0 : row_q + (bg_q ? 3'd2 : 3'd1);
                    end
                end
                ST_COLS: begin
                    frq_q <= frq_q + 3'd1;
                    if (frq_q == 3'd7) col_q <= col_q + 3'd1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_coef  <= '0;
        end else begin
            out_valid <= (state == ST_COLS);
            out_last  <= (state == ST_COLS) && frq_q == 3'd7 && col_q == 3'd7;
            out_coef  <= (state == ST_COLS) ? col_res : '0;
        end
    end

    // R2: block stays busy until the final coefficient is presented
    a_r2_busy_while_emitting: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready);

    // R5: the marker closes the tile's output stream
    a_r5_last_ends_stream: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);

    // R5: marker only on a valid coefficient
    a_r5_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6: tile type frozen outside the fill phase
    a_r6_flag_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FILL) |-> $stable(bg_q));

    // R9: flat tiles transform even rows only
    a_r9_even_rows_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROWS && bg_q) |-> !row_q[0]);

    // R9: columns of a flat tile hold equal row pairs
    a_r9_col_pairs_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLS && bg_q) |->
            (tbuf_vec[0] == tbuf_vec[1] && tbuf_vec[2] == tbuf_vec[3] &&
             tbuf_vec[4] == tbuf_vec[5] && tbuf_vec[6] == tbuf_vec[7]));

endmodule

// File: tb/dct8x8_adaptive_test.sv
module dct8x8_adaptive_test;

    localparam int PIX_W = 9;
    localparam int OUT_W = PIX_W + 4;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [PIX_W-1:0] in_pix;
    logic in_bg;
    logic in_ready;
    logic out_valid;
    logic signed [OUT_W-1:0] out_coef;
    logic out_last;

    always #10 clk = ~clk;

    dct8x8_adaptive uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .in_bg(in_bg), .in_ready(in_ready), .out_valid(out_valid),
        .out_coef(out_coef), .out_last(out_last)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    int exp_q[$];
    int lat_q[$];
    int acc_q[$];
    string tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic real bas(input int u, input int n);
        real a;
        a = (u == 0) ? $sqrt(1.0 / 8.0) : 0.5;
        return a * $cos((2.0 * n + 1.0) * u * 3.14159265358979 / 16.0);
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // driver: computes expectations, pushes them, then drives the tile
    task automatic send_block(input int pix[64], input bit bg, input bit flip, input string tag);
        int eff[64];
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                eff[r*8+c] = bg ? pix[(r & 6)*8 + (c & 6)] : pix[r*8+c];
            end
        end
        for (int v = 0; v < 8; v++) begin
            for (int u = 0; u < 8; u++) begin
                real s;
                s = 0.0;
                for (int r = 0; r < 8; r++) begin
                    for (int c = 0; c < 8; c++) begin
                        s += bas(u, r) * bas(v, c) * eff[r*8+c];
                    end
                end
                exp_q.push_back(int'(s));
            end
        end
        lat_q.push_back(bg ? 33 : 65);
        tag_q.push_back(tag);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_pix   = PIX_W'(pix[i]);
            in_bg    = (i == 0) ? bg : (flip ? ~bg : bg);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        acc_q.push_back(cyc);
    endtask

    // monitor: pops expectations and compares
    int idx = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (idx > 0 && !out_valid) begin
                checks++; fails++;
                $display("FAIL R4 stream gap at position %0d: out_valid=0 expected 1", idx);
                idx = 0;
            end
            if (out_valid) begin
                int e;
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R4 unexpected coefficient %0d, expected none", out_coef);
                end else begin
                    if (idx == 0) begin
                        int lat;
                        lat = cyc - acc_q.pop_front();
                        checks++;
                        if (lat != lat_q[0]) begin
                            fails++;
                            $display("FAIL R8 %s latency %0d expected %0d", tag_q[0], lat, lat_q[0]);
                        end
                        void'(lat_q.pop_front());
                    end
                    e = exp_q.pop_front();
                    checks++;
                    if (int'(out_coef) > e + 2 || int'(out_coef) < e - 2) begin
                        fails++;
                        $display("FAIL %s position %0d coef %0d expected %0d", tag_q[0], idx, out_coef, e);
                    end
                    checks++;
                    if (out_last != (idx == 63)) begin
                        fails++;
                        $display("FAIL R5 position %0d out_last=%0b expected %0b", idx, out_last, idx == 63);
                    end
                    checks++;
                    if (in_ready != (idx == 63)) begin
                        fails++;
                        $display("FAIL R2 position %0d in_ready=%0b expected %0b", idx, in_ready, idx == 63);
                    end
                    if (idx == 63) begin
                        void'(tag_q.pop_front());
                        idx = 0;
                    end else begin
                        idx++;
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired: run incomplete, expected completion");
        done = 1;
        report();
    end

    initial begin
        int p[64];
        rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; in_bg = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || out_last !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 valid=%0b last=%0b ready=%0b expected 0 0 1", out_valid, out_last, in_ready);
        end

        foreach (p[i]) p[i] = 0;
        send_block(p, 1'b0, 1'b0, "R3 zero tile");
        foreach (p[i]) p[i] = 255;
        send_block(p, 1'b0, 1'b0, "R10 constant 255");
        foreach (p[i]) p[i] = -256;
        send_block(p, 1'b0, 1'b0, "R10 constant -256");
        foreach (p[i]) p[i] = int'($urandom_range(0, 511)) - 256;
        send_block(p, 1'b0, 1'b0, "R3 random detail");
        foreach (p[i]) p[i] = (((i / 8) + (i % 8)) % 2 == 0) ? 255 : -256;
        send_block(p, 1'b0, 1'b0, "R3 checkerboard");
        foreach (p[i]) p[i] = (i % 8) * 60 - 220;
        send_block(p, 1'b0, 1'b0, "R4 horizontal ramp");
        foreach (p[i]) p[i] = int'($urandom_range(0, 511)) - 256;
        send_block(p, 1'b0, 1'b1, "R6 detail flag toggled late");
        foreach (p[i]) p[i] = int'($urandom_range(0, 511)) - 256;
        send_block(p, 1'b1, 1'b0, "R7 R9 flat with odd noise");
        foreach (p[i]) p[i] = int'($urandom_range(0, 511)) - 256;
        send_block(p, 1'b1, 1'b1, "R6 flat flag toggled late");
        foreach (p[i]) p[i] = (i / 8) * 30 - 100 + (i % 8) * 10;
        send_block(p, 1'b1, 1'b0, "R7 flat ramp");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1;
        report();
    end

endmodule